// File: doc/BRIEF.md
# Periodic down-counting timer with dual match events

The block is a periodic down-counter of parameterised width (32 bits by default). While it is enabled, every tick lowers the count by one, starting from a programmable reload value. After the count has stood at zero, the next tick brings it back to the reload value, so the timer runs indefinitely.

Two match values can be programmed in either order. Within one count-down period, the block raises an event when the count reaches the larger match value, then when it reaches the smaller one, and then when it reaches zero. The zero event is gated by an overflow-interrupt enable. Each event inverts a level-type interrupt line, so a rising edge and a falling edge each mean one event.

Software reaches the block through a small register port: a 2-bit index, a write strobe with write data, and combinational read data. Index 0 holds the live count, index 1 the reload value, and indexes 2 and 3 the two match values. Ticks come either from every system clock cycle or from an external tick input. The external input is synchronised and edge-detected before the counter uses it.

Top module: `dmt_timer`

## Requirements
- R1: After reset the count, the reload value and both match values read as zero, and `irq` is low.
- R2: While enabled, each tick lowers a nonzero count by exactly one; without a tick the count holds.
- R3: A tick that arrives while the count is zero loads the reload value. This load raises no event. With a reload value of zero the count stays at zero and no events are raised.
- R4: On the first clock edge with `en` high after it was low, the count is loaded from the reload value. While `en` is low the count holds its value and no events occur.
- R5: A decrement that brings the count to a nonzero value equal to either match value raises one event. The two match values may be in either order, so in one period the larger one fires before the smaller one. Equal nonzero match values raise a single event.
- R6: A decrement that brings the count to zero raises an event only if `ovf_irq_en` is 1 or at least one match value is zero.
- R7: Each event inverts `irq` on the same clock edge that updates the count. At every other edge `irq` keeps its level.
- R8: Writing index 0 while enabled replaces the count with the written data at that edge, and counting continues from there. Writing index 0 while disabled has no effect on the count.
- R9: With `tick_sel` = 0 every clock cycle is a tick. With `tick_sel` = 1 each rising edge of `ext_tick` gives exactly one tick, and the count changes on the third clock edge after the input is first sampled high. With `tick_sel` = 1 and `ext_tick` idle, the count holds.
- R10: `rd_data` shows the register selected by `reg_idx` (0 count, 1 reload, 2 match A, 3 match B) combinationally. Writes to indexes 1 to 3 are accepted at any time, and a match value written mid-period takes part in the comparisons for the rest of that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Timer enable; a rising level loads the reload value |
| tick_sel | input | 1 | Tick source: 0 system clock, 1 external tick |
| ovf_irq_en | input | 1 | Enables the event when the count reaches zero |
| ext_tick | input | 1 | Asynchronous external tick; one tick per rising edge |
| wr_en | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register index: 0 count, 1 reload, 2 match A, 3 match B |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Contents of the register selected by `reg_idx` |
| irq | output | 1 | Interrupt line that toggles once per event |

## Verification
The assertions assume that reset is held for at least one clock edge and that `en` and all register inputs are stable around the rising edge. They also assume that `ext_tick` stays at each level for longer than the synchroniser depth, so that no edge is lost. The stimulus drives every input on falling clock edges. It holds each level of `ext_tick` for four clock cycles and keeps `ext_tick` low whenever the system-clock source is selected. Pulses arrive only while the matches lie outside the range being counted, so the events seen on `irq` come only from the directed periods.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int IDX_W = 2;

  typedef enum logic [IDX_W-1:0] {
    SEL_COUNT   = 2'd0,
    SEL_RELOAD  = 2'd1,
    SEL_MATCH_A = 2'd2,
    SEL_MATCH_B = 2'd3
  } dmt_sel_e;
endpackage

// File: rtl/dmt_tick_src.sv
module dmt_tick_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_tick,
  input  logic tick_sel,
  output logic tick
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic ext_pulse;

  generate
    for (genvar g = 0; g < CHAIN_W; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= ext_tick;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  // rising edge of the synchronised level
  assign ext_pulse = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
  assign tick      = tick_sel ? ext_pulse : 1'b1;

  // R9: the edge detector yields single-cycle ticks
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ext_pulse |=> !ext_pulse);
endmodule

// File: rtl/dmt_regs.sv
module dmt_regs
  import dmt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [W-1:0]     wr_data,
  input  logic [W-1:0]     count,
  output logic [W-1:0]     reload,
  output logic [W-1:0]     match_a,
  output logic [W-1:0]     match_b,
  output logic             cnt_wr,
  output logic [W-1:0]     rd_data
);
  dmt_sel_e sel;
  assign sel    = dmt_sel_e'(reg_idx);
  assign cnt_wr = wr_en && (sel == SEL_COUNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload  <= '0;
      match_a <= '0;
      match_b <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_RELOAD:  reload  <= wr_data;
        SEL_MATCH_A: match_a <= wr_data;
        SEL_MATCH_B: match_b <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_COUNT:   rd_data = count;
      SEL_RELOAD:  rd_data = reload;
      SEL_MATCH_A: rd_data = match_a;
      default:     rd_data = match_b;
    endcase
  end

  // R10: a match write lands at the next edge
  a_r10_match_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_MATCH_A) |=> (match_a == $past(wr_data)));
endmodule

// File: rtl/dmt_counter.sv
module dmt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic         cnt_wr,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count,
  output logic         dec_step,
  output logic [W-1:0] next_val
);
  logic en_q;
  logic start;
  logic run;
  logic wrap;

  function automatic logic [W-1:0] dec1(input logic [W-1:0] v);
    return v - {{(W-1){1'b0}}, 1'b1};
  endfunction

  assign start    = en && !en_q;
  assign run      = en && en_q;
  assign wrap     = run && tick && !cnt_wr && (count == '0);
  assign dec_step = run && tick && !cnt_wr && (count != '0);
  assign next_val = dec1(count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      count <= '0;
    end else begin
      en_q <= en;
      if (start)              count <= reload;
      else if (run && cnt_wr) count <= wr_data;
      else if (wrap)          count <= reload;
      else if (dec_step)      count <= next_val;
    end
  end

  // R2: one step down per tick
  a_r2_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    dec_step |=> (count + 1'b1 == $past(count)));
  // R3: a tick at zero reloads
  a_r3_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count == $past(reload)));
  // R4: enabling loads the reload value
  a_r4_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (count == $past(reload)));
  // R4: a disabled counter keeps its value
  a_r4_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count));
  // R8: a count write while running replaces the count
  a_r8_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_wr) |=> (count == $past(wr_data)));
endmodule

// File: rtl/dmt_match_evt.sv
module dmt_match_evt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dec_step,
  input  logic [W-1:0] next_val,
  input  logic [W-1:0] match_a,
  input  logic [W-1:0] match_b,
  input  logic         ovf_irq_en,
  output logic         irq
);
  logic [W-1:0] m_hi;
  logic [W-1:0] m_lo;
  logic         hit_hi;
  logic         hit_lo;
  logic         hit_zero;
  logic         hit;

  function automatic logic [W-1:0] umax(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [W-1:0] umin(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a > b) ? b : a;
  endfunction

  function automatic logic zero_armed(input logic ovf, input logic [W-1:0] a,
                                      input logic [W-1:0] b);
    return ovf || (a == '0) || (b == '0);
  endfunction

  assign m_hi     = umax(match_a, match_b);
  assign m_lo     = umin(match_a, match_b);
  assign hit_hi   = (next_val != '0) && (next_val == m_hi);
  assign hit_lo   = (next_val != '0) && (next_val == m_lo) && (m_lo != m_hi);
  assign hit_zero = (next_val == '0) && zero_armed(ovf_irq_en, match_a, match_b);
  assign hit      = dec_step && (hit_hi || hit_lo || hit_zero);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else if (hit) irq <= ~irq;
  end

  // R7: the line moves only on an event
  a_r7_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(irq));
  // R7: every event flips the line
  a_r7_flip: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (irq != $past(irq)));
  // R5: at most one source per step
  a_r5_single_src: assert property (@(posedge clk) disable iff (!rst_n)
    dec_step |-> $onehot0({hit_hi, hit_lo, hit_zero}));
  // R6: an unarmed zero raises nothing
  a_r6_zero_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_step && next_val == '0 && !ovf_irq_en && match_a != '0 && match_b != '0)
      |=> $stable(irq));
endmodule

// File: rtl/dmt_timer.sv
module dmt_timer
  import dmt_pkg::*;
#(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick_sel,
  input  logic             ovf_irq_en,
  input  logic             ext_tick,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     rd_data,
  output logic             irq
);
  logic         tick;
  logic         cnt_wr;
  logic         dec_step;
  logic [W-1:0] count;
  logic [W-1:0] next_val;
  logic [W-1:0] reload;
  logic [W-1:0] match_a;
  logic [W-1:0] match_b;

  dmt_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .tick_sel(tick_sel), .tick(tick)
  );

  dmt_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_idx(reg_idx), .wr_data(wr_data),
    .count(count), .reload(reload), .match_a(match_a), .match_b(match_b),
    .cnt_wr(cnt_wr), .rd_data(rd_data)
  );

  dmt_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .cnt_wr(cnt_wr),
    .wr_data(wr_data), .reload(reload), .count(count), .dec_step(dec_step),
    .next_val(next_val)
  );

  dmt_match_evt #(.W(W)) u_evt (
    .clk(clk), .rst_n(rst_n), .dec_step(dec_step), .next_val(next_val),
    .match_a(match_a), .match_b(match_b), .ovf_irq_en(ovf_irq_en), .irq(irq)
  );
endmodule

// File: tb/test_dmt_timer.sv
module test_dmt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, tick_sel = 1'b0, ovf_irq_en = 1'b0, ext_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  reg_idx = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int total = 0, bad = 0, tog = 0;
  logic        prev_irq = 1'b0;
  logic [31:0] m_cnt = '0, m_rel = '0, m_a = '0, m_b = '0;
  logic        m_irq = 1'b0, m_enq = 1'b0;

  dmt_timer i_dmt_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .tick_sel(tick_sel), .ovf_irq_en(ovf_irq_en),
    .ext_tick(ext_tick), .wr_en(wr_en), .reg_idx(reg_idx), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock with the model of the requirements advanced alongside
  task automatic cyc(input string tag);
    logic [31:0] nv;
    logic hit;
    if (en) begin
      if (!m_enq) m_cnt = m_rel;
      else if (wr_en && reg_idx == 2'd0) m_cnt = wr_data;
      else if (!tick_sel) begin
        if (m_cnt == 0) m_cnt = m_rel;
        else begin
          nv  = m_cnt - 1;
          hit = (nv != 0 && (nv == m_a || nv == m_b)) ||
                (nv == 0 && (ovf_irq_en || m_a == 0 || m_b == 0));
          m_cnt = nv;
          if (hit) m_irq = ~m_irq;
        end
      end
    end
    m_enq = en;
    if (wr_en) begin
      case (reg_idx)
        2'd1: m_rel = wr_data;
        2'd2: m_a = wr_data;
        2'd3: m_b = wr_data;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    reg_idx = 2'd0;
    #1;
    chk({tag, " count"}, rd_data, m_cnt);
    chk({tag, " irq"}, {31'd0, irq}, {31'd0, m_irq});
    if (irq !== prev_irq) tog++;
    prev_irq = irq;
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d, input string tag);
    wr_en = 1'b1; reg_idx = idx; wr_data = d;
    cyc(tag);
  endtask

  task automatic period(input int r, input int exp_tog, input string tag);
    en = 1'b0; cyc(tag);
    en = 1'b1; tog = 0;
    for (int i = 0; i < r + 1; i++) cyc(tag);
    chk({tag, " events"}, tog, exp_tog);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) begin
      reg_idx = 2'(i); #1;
      chk("R1 reg", rd_data, 32'd0);
    end
    chk("R1 irq", {31'd0, irq}, 32'd0);
    reg_idx = 2'd0;
  endtask

  task automatic t_readback;
    wr(2'd1, 32'd20, "R10"); wr(2'd2, 32'd6, "R10"); wr(2'd3, 32'd14, "R10");
    reg_idx = 2'd1; #1 chk("R10 reload", rd_data, 32'd20);
    reg_idx = 2'd2; #1 chk("R10 matchA", rd_data, 32'd6);
    reg_idx = 2'd3; #1 chk("R10 matchB", rd_data, 32'd14);
    reg_idx = 2'd0;
  endtask

  task automatic t_orders;
    ovf_irq_en = 1'b0;
    period(20, 2, "R5 a<b");
    wr(2'd2, 32'd15, "R5"); wr(2'd3, 32'd5, "R5"); ovf_irq_en = 1'b1;
    period(20, 3, "R6 ovf on a>b");
    ovf_irq_en = 1'b0;
    wr(2'd2, 32'd9, "R5"); wr(2'd3, 32'd9, "R5");
    period(20, 1, "R5 equal");
    wr(2'd2, 32'd0, "R6"); wr(2'd3, 32'd12, "R6");
    period(20, 2, "R6 match0");
    for (int i = 0; i < 6; i++) cyc("R3 wrap");
  endtask

  task automatic t_sw_count;
    wr(2'd0, 32'd3, "R8 load");
    for (int i = 0; i < 6; i++) cyc("R8 run");
    en = 1'b0; cyc("R4 off");
    wr(2'd0, 32'd77, "R8 ignored");
    for (int i = 0; i < 3; i++) cyc("R4 hold");
    en = 1'b1; cyc("R4 load");
    cyc("R2");
  endtask

  task automatic t_zero_reload;
    en = 1'b0; cyc("R3");
    wr(2'd1, 32'd0, "R3"); wr(2'd2, 32'd3, "R3"); wr(2'd3, 32'd3, "R3");
    ovf_irq_en = 1'b1;
    period(10, 0, "R3 zero reload");
    ovf_irq_en = 1'b0;
  endtask

  task automatic t_mid_match;
    en = 1'b0; cyc("R10");
    wr(2'd1, 32'd30, "R10"); wr(2'd2, 32'd100, "R10"); wr(2'd3, 32'd100, "R10");
    en = 1'b1;
    for (int i = 0; i < 6; i++) cyc("R10");
    chk("R10 mid count", rd_data, 32'd25);
    wr(2'd2, 32'd20, "R10 mid write");
    tog = 0;
    for (int i = 0; i < 24; i++) cyc("R10 mid");
    chk("R10 mid events", tog, 32'd1);
  endtask

  task automatic t_ext;
    wr(2'd0, 32'd200, "R9 set");
    tick_sel = 1'b1;
    for (int i = 0; i < 5; i++) cyc("R9 idle hold");
    for (int p = 0; p < 5; p++) begin
      ext_tick = 1'b1; repeat (4) @(negedge clk);
      ext_tick = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    #1;
    m_cnt = m_cnt - 5;
    chk("R9 ext ticks", rd_data, m_cnt);
    chk("R9 irq", {31'd0, irq}, {31'd0, m_irq});
    // latency: count changes on the third edge after the input is sampled high
    ext_tick = 1'b1;
    @(negedge clk); @(negedge clk); #1;
    chk("R9 latency before", rd_data, m_cnt);
    @(negedge clk); #1;
    m_cnt = m_cnt - 1;
    chk("R9 latency at", rd_data, m_cnt);
    ext_tick = 1'b0;
    repeat (4) @(negedge clk);
    tick_sel = 1'b0;
    cyc("R2 back");
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_readback();
    t_orders();
    t_sw_count();
    t_zero_reload();
    t_mid_match();
    t_ext();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule